// File: doc/BRIEF.md
# Transfer Group Interrupt Flag Controller

This block gathers the events of one transfer group in a parallel digital I/O engine and turns them into readable flags and one interrupt request. The events are a FIFO-not-empty level, a handshake wait timeout, a primary and a secondary DMA terminal count, and the expiry of an internal transfer counter. Software reaches the block through a byte-wide register port. It reads the flags, masks them with an enable byte, clears them with write-one-to-clear bits, and chooses which interrupt line is driven and whether that line is push-pull or open-drain.

The clear bits sit in two registers. Clear register A clears the wait and terminal-count flags, and it can also pulse DMA and FIFO reset strobes. Clear register B is the only way to clear the count-expired flag. The transfer counter is loaded one byte at a time. It counts down once for each accepted sample while the run mode field equals 7, and it raises count-expired when it reaches zero, provided the numbered bit is set.

Top module: `grp_irq_ctrl`

Register map (4-bit address): 0 flags (R), 1 clear A (W), 2 clear B (W), 3 enable (R/W), 4 master control (R/W), 5 interrupt status (R), 6 group status (R), 7 operating mode (R/W), 8..11 transfer count bytes 0..3, least significant byte first (R/W). A read returns the addressed register on `rdata` one clock after `addr` is presented.

## Requirements
- R1: After reset, flags (with the FIFO level low), enable, master control, operating mode and all count bytes read 0, and `irq_oe` is 0.
- R2: Flag bits 5 (waited), 6 (primary terminal count), 7 (secondary terminal count) and 1 (count expired) are sticky: each is set by its event and keeps its value until it is cleared.
- R3: A write to clear A clears flag 5 with data bit 3, flag 6 with data bit 4 and flag 7 with data bit 5. It leaves the other flags unchanged.
- R4: Count expired (flag 1) is cleared only by writing data bit 0 of clear B. Writing 0xFF to clear A leaves it set.
- R5: When a set event and its clear bit arrive in the same cycle, the flag ends set.
- R6: Flag bit 0 follows the FIFO-not-empty input as a live level. It has no clear bit and does not stick.
- R7: The enable register masks the flags bit for bit, using the flag positions. A flag is pending when it and its enable bit are both 1.
- R8: Master control bits 1:0 select interrupt line 1..3 (value 0 drives none), and bit 2 selects open-drain. In push-pull mode the selected line has `irq_oe` high and `irq_pin` equal to the pending state. In open-drain mode `irq_pin` is 0 and `irq_oe` is high only while something is pending. Both outputs are registered.
- R9: Group status bit 0 is high when any flag is pending (independent of master control). Bit 2 reflects the request input and bit 3 reflects the stop-trigger input. The other bits read 0.
- R10: While operating mode bits 2:0 equal 7, each sample strobe decrements the transfer count by one. The count saturates at zero. A byte load takes priority over a decrement in the same cycle.
- R11: A decrement from 1 to 0 sets count expired only when operating mode bit 3 is also set.
- R12: After operating mode is written with 0, sample strobes leave the count unchanged, and `run_on` is low.
- R13: Clear A data bit 6 produces a one-cycle `dma_rst_p` pulse and data bit 7 produces a one-cycle `fifo_rst_p` pulse, both in the cycle after the write.
- R14: Interrupt status bit 0 is high when an interrupt is pending and a line is selected. Bit 1 is high when any flag is set, masked or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| fifo_ne | input | 1 | FIFO not-empty level |
| sample_stb | input | 1 | One accepted sample |
| wait_tmo | input | 1 | Handshake wait timeout strobe |
| tc_pri | input | 1 | Primary DMA terminal count strobe |
| tc_sec | input | 1 | Secondary DMA terminal count strobe |
| req_in | input | 1 | Handshake request line level |
| stop_in | input | 1 | Stop trigger level |
| irq_pin | output | 2**SEL_W-1 | Interrupt line value, one per line |
| irq_oe | output | 2**SEL_W-1 | Interrupt line drive enable |
| dma_rst_p | output | 1 | DMA reset pulse |
| fifo_rst_p | output | 1 | FIFO reset pulse |
| run_on | output | 1 | Run mode 7 active |

## Verification
The assertions assume that the event strobes, `sample_stb` and `wr_en` are valid only at clock edges and return to zero before reset is released. They also assume that a byte write to the count takes effect at once, with no shadow copy. The stimulus drives every input at the falling edge and returns each strobe to zero one cycle later. Random mixes of events, clears, byte loads and mode writes share cycles, so same-cycle set and clear cases happen as well as the directed ones.

// File: rtl/gic_pkg.sv
package gic_pkg;
  // flag bit positions (also used by the enable register)
  localparam int FB_RDY  = 0;
  localparam int FB_EXP  = 1;
  localparam int FB_WAIT = 5;
  localparam int FB_PTC  = 6;
  localparam int FB_STC  = 7;
  localparam logic [7:0] STICKY_MASK = 8'hE2;

  // clear A data bits
  localparam int CA_WAIT = 3;
  localparam int CA_PTC  = 4;
  localparam int CA_STC  = 5;
  localparam int CA_DMA  = 6;
  localparam int CA_FIFO = 7;
  // clear B data bit
  localparam int CB_EXP  = 0;

  // register addresses
  localparam int A_FLAGS  = 0;
  localparam int A_CLRA   = 1;
  localparam int A_CLRB   = 2;
  localparam int A_IEN    = 3;
  localparam int A_MCTRL  = 4;
  localparam int A_ISTAT  = 5;
  localparam int A_GSTAT  = 6;
  localparam int A_OPMODE = 7;
  localparam int A_CNT0   = 8;

  localparam logic [2:0] RUN_FULL = 3'd7;
  localparam int OP_NUMBERED = 3;
endpackage

// File: rtl/gic_flag_bank.sv
module gic_flag_bank #(
  parameter int W = 8,
  parameter logic [W-1:0] STICKY = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (STICKY[i]) begin : g_sticky
      always_ff @(posedge clk) begin
        if (rst) q[i] <= 1'b0;
        else     q[i] <= set_i[i] | (q[i] & ~clr_i[i]);
      end

      // R5
      set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        set_i[i] |=> q[i]);
      // R2
      sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (q[i] && !clr_i[i]) |=> q[i]);
    end else begin : g_none
      assign q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/gic_xfer_cnt.sv
module gic_xfer_cnt #(
  parameter int CNT_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CNT_W/8-1:0] ld_en,
  input  logic [7:0]         ld_byte,
  input  logic               stb,
  input  logic               run_en,
  input  logic               numbered,
  output logic [CNT_W-1:0]   cnt_q,
  output logic               expire
);
  localparam int NB = CNT_W / 8;

  logic dec;
  logic any_ld;

  assign any_ld = |ld_en;
  assign dec    = stb && run_en && (cnt_q != '0);
  assign expire = dec && numbered && !any_ld && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (any_ld) begin
      for (int k = 0; k < NB; k++)
        if (ld_en[k]) cnt_q[8*k +: 8] <= ld_byte;
    end else if (dec) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  // R10
  cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && !any_ld) |=> (cnt_q == '0));
  // R11
  expire_zero_chk: assert property (@(posedge clk) disable iff (rst)
    expire |=> (cnt_q == '0));
  // R12
  halt_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_en && !any_ld) |=> $stable(cnt_q));
endmodule

// File: rtl/gic_irq_drive.sv
module gic_irq_drive #(
  parameter int SEL_W = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   pend,
  input  logic [SEL_W-1:0]       sel,
  input  logic                   od,
  output logic [2**SEL_W-2:0]    pin,
  output logic [2**SEL_W-2:0]    oe
);
  localparam int NLINE = 2**SEL_W - 1;

  for (genvar l = 0; l < NLINE; l++) begin : g_line
    logic hit;
    assign hit = (sel == SEL_W'(l + 1));
    always_ff @(posedge clk) begin
      if (rst) begin
        pin[l] <= 1'b0;
        oe[l]  <= 1'b0;
      end else begin
        pin[l] <= hit && !od && pend;
        oe[l]  <= hit && (od ? pend : 1'b1);
      end
    end
  end

  // R8
  oe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(oe));
  // R8
  sel_off_chk: assert property (@(posedge clk) disable iff (rst)
    (sel == '0) |=> (oe == '0));
endmodule

// File: rtl/grp_irq_ctrl.sv
module grp_irq_ctrl
  import gic_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 32,
  parameter int SEL_W  = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [7:0]          wdata,
  output logic [7:0]          rdata,
  input  logic                fifo_ne,
  input  logic                sample_stb,
  input  logic                wait_tmo,
  input  logic                tc_pri,
  input  logic                tc_sec,
  input  logic                req_in,
  input  logic                stop_in,
  output logic [2**SEL_W-2:0] irq_pin,
  output logic [2**SEL_W-2:0] irq_oe,
  output logic                dma_rst_p,
  output logic                fifo_rst_p,
  output logic                run_on
);
  localparam int NB   = CNT_W / 8;
  localparam int MC_W = SEL_W + 1;

  logic [7:0]       ien_q;
  logic [MC_W-1:0]  mctrl_q;
  logic [7:0]       opmode_q;
  logic [7:0]       sticky_q;
  logic [7:0]       flags_vis;
  logic [7:0]       set_v;
  logic [7:0]       clr_v;
  logic [NB-1:0]    ld_en;
  logic [CNT_W-1:0] cnt_q;
  logic             expire;
  logic             wr_clra, wr_clrb;
  logic             pend, irq_asrt;
  logic [7:0]       rd_mux;

  assign wr_clra = wr_en && (addr == ADDR_W'(A_CLRA));
  assign wr_clrb = wr_en && (addr == ADDR_W'(A_CLRB));

  always_comb begin
    for (int k = 0; k < NB; k++)
      ld_en[k] = wr_en && (addr == ADDR_W'(A_CNT0 + k));
  end

  always_comb begin
    set_v          = '0;
    set_v[FB_WAIT] = wait_tmo;
    set_v[FB_PTC]  = tc_pri;
    set_v[FB_STC]  = tc_sec;
    set_v[FB_EXP]  = expire;
    clr_v          = '0;
    clr_v[FB_WAIT] = wr_clra && wdata[CA_WAIT];
    clr_v[FB_PTC]  = wr_clra && wdata[CA_PTC];
    clr_v[FB_STC]  = wr_clra && wdata[CA_STC];
    clr_v[FB_EXP]  = wr_clrb && wdata[CB_EXP];
  end

  gic_flag_bank #(.W(8), .STICKY(STICKY_MASK)) u_flags (
    .clk(clk), .rst(rst), .set_i(set_v), .clr_i(clr_v), .q(sticky_q)
  );

  assign run_on = (opmode_q[2:0] == RUN_FULL);

  gic_xfer_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_byte(wdata),
    .stb(sample_stb), .run_en(run_on), .numbered(opmode_q[OP_NUMBERED]),
    .cnt_q(cnt_q), .expire(expire)
  );

  always_comb begin
    flags_vis         = sticky_q;
    flags_vis[FB_RDY] = fifo_ne;
  end

  assign pend     = |(flags_vis & ien_q);
  assign irq_asrt = pend && (mctrl_q[SEL_W-1:0] != '0);

  gic_irq_drive #(.SEL_W(SEL_W)) u_drv (
    .clk(clk), .rst(rst), .pend(pend), .sel(mctrl_q[SEL_W-1:0]),
    .od(mctrl_q[SEL_W]), .pin(irq_pin), .oe(irq_oe)
  );

  // control registers and reset pulses
  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q      <= '0;
      mctrl_q    <= '0;
      opmode_q   <= '0;
      dma_rst_p  <= 1'b0;
      fifo_rst_p <= 1'b0;
    end else begin
      if (wr_en && addr == ADDR_W'(A_IEN))    ien_q    <= wdata;
      if (wr_en && addr == ADDR_W'(A_MCTRL))  mctrl_q  <= wdata[MC_W-1:0];
      if (wr_en && addr == ADDR_W'(A_OPMODE)) opmode_q <= wdata;
      dma_rst_p  <= wr_clra && wdata[CA_DMA];
      fifo_rst_p <= wr_clra && wdata[CA_FIFO];
    end
  end

  // read mux
  always_comb begin
    rd_mux = '0;
    if (addr == ADDR_W'(A_FLAGS))  rd_mux = flags_vis;
    if (addr == ADDR_W'(A_IEN))    rd_mux = ien_q;
    if (addr == ADDR_W'(A_MCTRL))  rd_mux = 8'(mctrl_q);
    if (addr == ADDR_W'(A_ISTAT))  rd_mux = {6'b0, |flags_vis, irq_asrt};
    if (addr == ADDR_W'(A_GSTAT))  rd_mux = {4'b0, stop_in, req_in, 1'b0, pend};
    if (addr == ADDR_W'(A_OPMODE)) rd_mux = opmode_q;
    for (int k = 0; k < NB; k++)
      if (addr == ADDR_W'(A_CNT0 + k)) rd_mux = cnt_q[8*k +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  // R13
  dma_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_clra && wdata[CA_DMA]) |=> dma_rst_p);
  // R4
  exp_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (sticky_q[FB_EXP] && !clr_v[FB_EXP]) |=> sticky_q[FB_EXP]);
endmodule

// File: tb/grp_irq_ctrl_tb.sv
`timescale 1ns/1ps
module grp_irq_ctrl_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst, wr_en, fifo_ne, sample_stb, wait_tmo, tc_pri, tc_sec, req_in, stop_in;
  logic [3:0] addr;
  logic [7:0] wdata, rdata;
  logic [2:0] irq_pin, irq_oe;
  logic       dma_rst_p, fifo_rst_p, run_on;

  grp_irq_ctrl u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .fifo_ne(fifo_ne), .sample_stb(sample_stb), .wait_tmo(wait_tmo), .tc_pri(tc_pri),
    .tc_sec(tc_sec), .req_in(req_in), .stop_in(stop_in), .irq_pin(irq_pin),
    .irq_oe(irq_oe), .dma_rst_p(dma_rst_p), .fifo_rst_p(fifo_rst_p), .run_on(run_on)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0]  m_st = 0, m_ien = 0, m_op = 0;
  logic [2:0]  m_mc = 0;
  logic [31:0] m_cnt = 0;
  logic        seen_dma, seen_fifo;
  logic [7:0]  rv;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] vis();
    return m_st | {7'b0, fifo_ne};
  endfunction
  function automatic logic pend_f();
    return |(vis() & m_ien);
  endfunction

  // one cycle: events, sample strobe and an optional register write
  task automatic step(input logic [7:0] ev, input logic stb, input logic w,
                      input logic [3:0] a, input logic [7:0] d);
    logic [7:0] setv, clrv;
    logic ld;
    @(negedge clk);
    wait_tmo = ev[5]; tc_pri = ev[6]; tc_sec = ev[7]; sample_stb = stb;
    wr_en = w; addr = a; wdata = d;
    setv = ev & 8'hE0; clrv = 0;
    if (w && a == 1) begin clrv[5] = d[3]; clrv[6] = d[4]; clrv[7] = d[5]; end
    if (w && a == 2) clrv[1] = d[0];
    ld = w && a >= 8 && a <= 11;
    if (ld) m_cnt[(a-8)*8 +: 8] = d;
    else if (stb && m_op[2:0] == 3'd7 && m_cnt != 0) begin
      if (m_cnt == 1 && m_op[3]) setv[1] = 1'b1;
      m_cnt = m_cnt - 1;
    end
    m_st = setv | (m_st & ~clrv);
    if (w && a == 3) m_ien = d;
    if (w && a == 4) m_mc = d[2:0];
    if (w && a == 7) m_op = d;
    @(negedge clk);
    seen_dma = dma_rst_p; seen_fifo = fifo_rst_p;
    wait_tmo = 0; tc_pri = 0; tc_sec = 0; sample_stb = 0; wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk); addr = a;
    @(negedge clk); v = rdata;
  endtask

  task automatic chk_irq(input string tag);
    logic [2:0] ep, eo;
    for (int l = 0; l < 3; l++) begin
      logic hit;
      hit = (m_mc[1:0] == 2'(l + 1));
      ep[l] = hit && !m_mc[2] && pend_f();
      eo[l] = hit && (m_mc[2] ? pend_f() : 1'b1);
    end
    chk({tag, " pin"}, 32'(irq_pin), 32'(ep));
    chk({tag, " oe"},  32'(irq_oe),  32'(eo));
  endtask

  task automatic chk_flags(input string tag);
    rd(4'd0, rv);
    chk(tag, 32'(rv), 32'(vis()));
    chk_irq(tag);
  endtask

  task automatic chk_cnt(input string tag);
    for (int k = 0; k < 4; k++) begin
      rd(4'(8 + k), rv);
      chk(tag, 32'(rv), 32'(m_cnt[k*8 +: 8]));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1; wr_en = 0; addr = 0; wdata = 0; fifo_ne = 0; sample_stb = 0;
    wait_tmo = 0; tc_pri = 0; tc_sec = 0; req_in = 0; stop_in = 0;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    rd(4'd0, rv); chk("R1 flags", 32'(rv), 0);
    rd(4'd3, rv); chk("R1 ien", 32'(rv), 0);
    rd(4'd4, rv); chk("R1 mctrl", 32'(rv), 0);
    rd(4'd7, rv); chk("R1 opmode", 32'(rv), 0);
    chk_cnt("R1 count");
    chk("R1 oe", 32'(irq_oe), 0);

    // R6 live transfer-ready level
    fifo_ne = 1; step(0, 0, 0, 0, 0);
    rd(4'd0, rv); chk("R6 ready high", 32'(rv), 32'h01);
    fifo_ne = 0; step(0, 0, 0, 0, 0);
    rd(4'd0, rv); chk("R6 ready low", 32'(rv), 32'h00);

    // R2 sticky waited
    step(8'h20, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    rd(4'd0, rv); chk("R2 waited sticky", 32'(rv), 32'h20);

    // R3 clear A selective
    step(8'hC0, 0, 0, 0, 0);
    step(0, 0, 1, 4'd1, 8'h10);
    rd(4'd0, rv); chk("R3 clear pri only", 32'(rv), 32'hA0);
    step(0, 0, 1, 4'd1, 8'h28);
    rd(4'd0, rv); chk("R3 clear wait+sec", 32'(rv), 32'h00);

    // R11 R4 counter expiry and its own clear
    step(0, 0, 1, 4'd8, 8'h02);
    step(0, 0, 1, 4'd7, 8'h0F);
    chk("R10 run_on", 32'(run_on), 1);
    step(0, 1, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    rd(4'd0, rv); chk("R11 expired set", 32'(rv), 32'h02);
    chk_cnt("R10 count zero");
    step(0, 0, 1, 4'd1, 8'hFF);
    chk("R13 dma pulse", 32'(seen_dma), 1);
    chk("R13 fifo pulse", 32'(seen_fifo), 1);
    rd(4'd0, rv); chk("R4 clearA keeps expired", 32'(rv), 32'h02);
    chk("R13 pulse one cycle", 32'(dma_rst_p), 0);
    step(0, 0, 1, 4'd2, 8'h01);
    rd(4'd0, rv); chk("R4 clearB clears", 32'(rv), 32'h00);

    // R10 saturation
    step(0, 1, 0, 0, 0);
    chk_cnt("R10 saturate");

    // R5 set wins
    step(8'h40, 0, 1, 4'd1, 8'h10);
    rd(4'd0, rv); chk("R5 set wins", 32'(rv), 32'h40);

    // R12 halt
    step(0, 0, 1, 4'd7, 8'h00);
    chk("R12 run_on low", 32'(run_on), 0);
    step(0, 0, 1, 4'd8, 8'h05);
    step(0, 1, 0, 0, 0);
    chk_cnt("R12 halted");

    // R11 unnumbered run: no expiry
    step(0, 0, 1, 4'd2, 8'h01);
    step(0, 0, 1, 4'd8, 8'h01);
    step(0, 0, 1, 4'd7, 8'h07);
    step(0, 1, 0, 0, 0);
    chk_cnt("R11 unnumbered count");
    rd(4'd0, rv); chk("R11 no expiry", 32'(rv), 32'h40);

    // R7 R8 masking and line drive
    step(0, 0, 1, 4'd3, 8'h80);
    step(0, 0, 1, 4'd4, 8'h03);
    chk_flags("R7 masked");
    step(0, 0, 1, 4'd3, 8'h40);
    chk_flags("R7 enabled");
    chk("R8 line3 push-pull", 32'({irq_oe, irq_pin}), 32'h24);
    step(0, 0, 1, 4'd4, 8'h06);
    chk_flags("R8 open-drain");
    chk("R8 line2 od", 32'({irq_oe, irq_pin}), 32'h10);

    // R9 R14 status registers
    req_in = 1; stop_in = 1;
    rd(4'd6, rv); chk("R9 group status", 32'(rv), 32'h0D);
    rd(4'd5, rv); chk("R14 int status", 32'(rv), 32'h03);
    step(0, 0, 1, 4'd4, 8'h00);
    rd(4'd5, rv); chk("R14 no line", 32'(rv), 32'h02);
    chk("R8 sel0 off", 32'(irq_oe), 0);
    req_in = 0;
    rd(4'd6, rv); chk("R9 req low", 32'(rv), 32'h09);
    stop_in = 0;

    // random mix
    for (int it = 0; it < 400; it++) begin
      logic [7:0] ev, d;
      logic [3:0] a;
      logic w;
      int sel;
      ev = 8'($urandom) & 8'hE0;
      if ($urandom_range(0, 2) != 0) ev = 0;
      fifo_ne = ($urandom_range(0, 3) == 0);
      d = 8'($urandom);
      w = 1;
      sel = $urandom_range(0, 9);
      case (sel)
        0, 1: a = 4'd1;
        2:    a = 4'd2;
        3:    a = 4'd3;
        4:    begin a = 4'd4; d = d & 8'h07; end
        5:    begin a = 4'd7; d = (d[0]) ? 8'h0F : ((d[1]) ? 8'h07 : 8'h00); end
        6:    begin a = 4'd8; d = d & 8'h03; end
        default: begin a = 4'd0; w = 0; end
      endcase
      step(ev, $urandom_range(0, 1) == 1, w, a, d);
      chk_flags("R2 R3 R5 rand");
      if (it % 16 == 0) chk_cnt("R10 rand");
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule